// File: doc/BRIEF.md
# Data-Space Decoder

This block owns the byte-addressed data space of a small 8-bit controller and resolves every data access to one flat store. The low 32 bytes hold the general registers, the next 64 bytes hold the I/O registers, and the 2 KB scratch SRAM follows from 0x60 up to 0x85F. A single request port carries an operation code that says how the byte address is formed: a full data address, one of three register-pair pointers, a short I/O address, or a register index for an immediate load.

Because the registers live inside the same store, a plain data store to a low address changes a general register. A short I/O access and a data access 0x20 higher reach the same byte. The block also does single-bit set and clear on I/O bytes in place. The three 16-bit pointers are read straight out of the register bytes and driven on dedicated outputs.

Top module: `dspace_decoder`

## Requirements
- R1: Data addresses 0x000-0x01F reach general registers 0-31, 0x020-0x05F reach the 64 I/O bytes, and 0x060-0x85F reach the SRAM. A byte written at any of these addresses reads back from the same address.
- R2: An op code 3 (short I/O) access at I/O address a (0-63) reaches the same byte as an op code 1 (direct) access at data address a+0x20.
- R3: A direct store (op 1) to 0x01 updates register 1, as seen by an op 4 read of register index 1. Writes to bytes 26-31 appear on x_ptr = {byte27,byte26}, y_ptr = {byte29,byte28} and z_ptr = {byte31,byte30}.
- R4: An op 2 (indirect) access uses the data address x_ptr when ptr_sel is 0, y_ptr when it is 1, and z_ptr when it is 2 or 3.
- R5: The status byte at I/O address 0x3F is the byte at data address 0x5F.
- R6: Op 5 sets and op 6 clears bit bit_idx (0-7) of the I/O byte at io_addr when wr_en is high. The other seven bits do not change.
- R7: Op 4 with wr_en high and reg_idx below 16 raises illegal in that cycle and writes nothing. Indices 16-31 write normally.
- R8: An op 1 or op 2 access above 0x85F, with rd_en or wr_en high, raises oor. Its read returns 0x00 and its write changes no byte.
- R9: After reset every register, I/O byte and SRAM byte reads as 0x00.
- R10: Writes take effect on the rising clock edge. rdata is combinational in the same cycle, shows the value from before that edge, and is 0x00 when rd_en is low or op is 0 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; clears the whole store |
| op | input | 3 | 0/7 idle, 1 direct, 2 indirect, 3 short I/O, 4 immediate-load target, 5 bit set, 6 bit clear |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| daddr | input | 16 | Data address for op 1 |
| ptr_sel | input | 2 | Pointer select for op 2 (0 X, 1 Y, 2/3 Z) |
| io_addr | input | 6 | Short I/O address for ops 3, 5 and 6 |
| reg_idx | input | 5 | Register index for op 4 |
| bit_idx | input | 3 | Bit index for ops 5 and 6 |
| wdata | input | 8 | Write data for ops 1 to 4 |
| rdata | output | 8 | Read data |
| oor | output | 1 | Out-of-range access flag |
| illegal | output | 1 | Low-register immediate-load flag |
| x_ptr | output | 16 | Pointer from bytes 27:26 |
| y_ptr | output | 16 | Pointer from bytes 29:28 |
| z_ptr | output | 16 | Pointer from bytes 31:30 |

## Verification
The hardest case to reach from the ports is an indirect access through a pointer that the same sequence has just built. The pointer bytes must first be loaded through the immediate-load path or through direct stores to 26-31. Only then can a store go through X, Y or Z, and the result has to be read back by a different address form. The bench builds pointers this way, including an out-of-range pointer of 0xFFFF. It then runs a long stream of mixed operations in which pointer bytes are often hit by random stores, so that indirect targets keep moving. Each cycle is compared against a behavioural byte-array model.

// File: rtl/dspace_decoder.sv
module dspace_decoder #(
  parameter int GPR_N  = 32,
  parameter int IO_N   = 64,
  parameter int SRAM_N = 2048,
  parameter int AW     = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [2:0]              op,
  input  logic                    rd_en,
  input  logic                    wr_en,
  input  logic [AW-1:0]           daddr,
  input  logic [1:0]              ptr_sel,
  input  logic [$clog2(IO_N)-1:0] io_addr,
  input  logic [$clog2(GPR_N)-1:0] reg_idx,
  input  logic [2:0]              bit_idx,
  input  logic [7:0]              wdata,
  output logic [7:0]              rdata,
  output logic                    oor,
  output logic                    illegal,
  output logic [AW-1:0]           x_ptr,
  output logic [AW-1:0]           y_ptr,
  output logic [AW-1:0]           z_ptr
);
  localparam int TOTAL   = GPR_N + IO_N + SRAM_N;
  localparam int IDXW    = $clog2(TOTAL);
  localparam int LDI_MIN = GPR_N / 2;
  localparam int XL      = GPR_N - 6;

  logic [7:0]    mem [TOTAL];
  logic [AW-1:0] ea;
  logic          active, in_range, wr_ok;
  logic [7:0]    cur, nxt, mask;

  assign x_ptr = {mem[XL+1], mem[XL]};
  assign y_ptr = {mem[XL+3], mem[XL+2]};
  assign z_ptr = {mem[XL+5], mem[XL+4]};

  always_comb begin
    case (op)
      3'd1:    ea = daddr;
      3'd2:    ea = (ptr_sel == 2'd0) ? x_ptr : (ptr_sel == 2'd1) ? y_ptr : z_ptr;
      3'd3, 3'd5, 3'd6: ea = AW'(GPR_N) + AW'(io_addr);
      3'd4:    ea = AW'(reg_idx);
      default: ea = '0;
    endcase
  end

  assign active   = (op != 3'd0) && (op != 3'd7);
  assign in_range = ea < AW'(TOTAL);
  assign illegal  = (op == 3'd4) && wr_en && (reg_idx < LDI_MIN);
  assign oor      = active && (rd_en || wr_en) && !in_range;
  assign wr_ok    = active && wr_en && in_range && !illegal;
  assign cur      = in_range ? mem[ea[IDXW-1:0]] : 8'h00;
  assign mask     = 8'h01 << bit_idx;
  assign nxt      = (op == 3'd5) ? (cur | mask) :
                    (op == 3'd6) ? (cur & ~mask) : wdata;
  assign rdata    = (rd_en && active && in_range) ? cur : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TOTAL; i++) mem[i] <= 8'h00;
    end else if (wr_ok) begin
      mem[ea[IDXW-1:0]] <= nxt;
    end
  end
endmodule

// File: rtl/dspace_decoder_chk.sv
module dspace_decoder_chk #(
  parameter int TOTAL = 2144,
  parameter int IDXW  = 12,
  parameter int AW    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       op,
  input logic             rd_en,
  input logic             wr_en,
  input logic [5:0]       io_addr,
  input logic [4:0]       reg_idx,
  input logic [2:0]       bit_idx,
  input logic [7:0]       rdata,
  input logic             oor,
  input logic             illegal,
  input logic [AW-1:0]    ea,
  input logic [7:0]       mem [TOTAL]
);
  a_r8_oor_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (oor && rd_en) |-> rdata == 8'h00);

  a_r8_oor_only_long_forms: assert property (@(posedge clk) disable iff (!rst_n)
    oor |-> (op == 3'd1 || op == 3'd2));

  a_r7_low_reg_kept: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> mem[$past(IDXW'(reg_idx))] == $past(mem[IDXW'(reg_idx)]));

  a_r2_short_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd3 && rd_en) |-> rdata == mem[IDXW'(io_addr) + IDXW'(32)]);

  a_r6_one_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd5 && wr_en) |=>
      mem[$past(ea[IDXW-1:0])][$past(bit_idx)] == 1'b1 &&
      ((mem[$past(ea[IDXW-1:0])] ^ $past(mem[ea[IDXW-1:0]])) & ~(8'h01 << $past(bit_idx))) == 8'h00);

  a_r6_one_bit_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd6 && wr_en) |=>
      mem[$past(ea[IDXW-1:0])][$past(bit_idx)] == 1'b0 &&
      ((mem[$past(ea[IDXW-1:0])] ^ $past(mem[ea[IDXW-1:0]])) & ~(8'h01 << $past(bit_idx))) == 8'h00);
endmodule

bind dspace_decoder dspace_decoder_chk chk_i (.*);

// File: tb/dspace_decoder_tb_top.sv
`timescale 1ns/100ps
module dspace_decoder_tb_top;
  localparam int TOTAL = 2144;
  logic clk = 0, rst_n = 0;
  logic [2:0] op = 0;
  logic rd_en = 0, wr_en = 0;
  logic [15:0] daddr = 0;
  logic [1:0] ptr_sel = 0;
  logic [5:0] io_addr = 0;
  logic [4:0] reg_idx = 0;
  logic [2:0] bit_idx = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic oor, illegal;
  logic [15:0] x_ptr, y_ptr, z_ptr;

  int mdl [TOTAL];
  int nvec = 0, nbad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dspace_decoder dut_i (.*);

  function automatic int ptr_of(int lo);
    return mdl[lo+1] * 256 + mdl[lo];
  endfunction

  function automatic int addr_of(int o, int d, int p, int io, int ri);
    case (o)
      1: return d;
      2: return (p == 0) ? ptr_of(26) : (p == 1) ? ptr_of(28) : ptr_of(30);
      3, 5, 6: return io + 32;
      4: return ri;
      default: return -1;
    endcase
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic vec(string tag, int o, bit rd, bit wr, int d, int p, int io, int ri,
                     int bi, int wd);
    int a, e_rd, nv;
    bit inr, ill, ob;
    @(negedge clk);
    op = 3'(o); rd_en = rd; wr_en = wr; daddr = 16'(d); ptr_sel = 2'(p);
    io_addr = 6'(io); reg_idx = 5'(ri); bit_idx = 3'(bi); wdata = 8'(wd);
    #1;
    a   = addr_of(o, d, p, io, ri);
    inr = (a >= 0) && (a < TOTAL);
    ill = (o == 4) && wr && (ri < 16);
    ob  = (a >= 0) && (rd || wr) && !inr;
    e_rd = (rd && inr) ? mdl[a] : 0;
    chk(tag, "rdata", int'(rdata), e_rd);
    chk(tag, "oor", int'(oor), int'(ob));
    chk(tag, "illegal", int'(illegal), int'(ill));
    chk("R3", "x_ptr", int'(x_ptr), ptr_of(26));
    chk("R3", "y_ptr", int'(y_ptr), ptr_of(28));
    chk("R3", "z_ptr", int'(z_ptr), ptr_of(30));
    @(posedge clk);
    if (wr && inr && !ill) begin
      nv = (o == 5) ? (mdl[a] | (1 << bi)) : (o == 6) ? (mdl[a] & ~(1 << bi) & 255) : wd;
      mdl[a] = nv;
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < TOTAL; i++) mdl[i] = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R9 reset values
    vec("R9", 1, 1, 0, 'h000, 0, 0, 0, 0, 0);
    vec("R9", 1, 1, 0, 'h05F, 0, 0, 0, 0, 0);
    vec("R9", 1, 1, 0, 'h85F, 0, 0, 0, 0, 0);
    // R1 region boundaries
    begin
      int bnd[6] = '{'h000, 'h01F, 'h020, 'h05F, 'h060, 'h85F};
      foreach (bnd[k]) vec("R1", 1, 0, 1, bnd[k], 0, 0, 0, 0, 'h11 + k * 16);
      foreach (bnd[k]) vec("R1", 1, 1, 0, bnd[k], 0, 0, 0, 0, 0);
    end
    // R3 direct store to a register
    vec("R3", 1, 0, 1, 'h001, 0, 0, 0, 0, 'h7E);
    vec("R3", 4, 1, 0, 0, 0, 0, 1, 0, 0);
    // R2 short/long aliasing both ways
    vec("R2", 3, 0, 1, 0, 0, 5, 0, 0, 'hA5);
    vec("R2", 1, 1, 0, 'h025, 0, 0, 0, 0, 0);
    vec("R2", 1, 0, 1, 'h030, 0, 0, 0, 0, 'h3C);
    vec("R2", 3, 1, 0, 0, 0, 'h10, 0, 0, 0);
    // R5 status byte
    vec("R5", 3, 0, 1, 0, 0, 'h3F, 0, 0, 'h83);
    vec("R5", 1, 1, 0, 'h05F, 0, 0, 0, 0, 0);
    // R4 pointers built through immediate loads
    vec("R4", 4, 0, 1, 0, 0, 0, 26, 0, 'h38);
    vec("R4", 4, 0, 1, 0, 0, 0, 27, 0, 'h02);
    vec("R4", 4, 0, 1, 0, 0, 0, 28, 0, 'h40);
    vec("R4", 4, 0, 1, 0, 0, 0, 29, 0, 'h01);
    vec("R4", 1, 0, 1, 'h01E, 0, 0, 0, 0, 'h22);
    vec("R4", 1, 0, 1, 'h01F, 0, 0, 0, 0, 'h00);
    vec("R4", 2, 0, 1, 0, 0, 0, 0, 0, 'hFB);
    vec("R4", 1, 1, 0, 'h238, 0, 0, 0, 0, 0);
    vec("R4", 2, 0, 1, 0, 1, 0, 0, 0, 'h5D);
    vec("R4", 1, 1, 0, 'h140, 0, 0, 0, 0, 0);
    vec("R4", 2, 0, 1, 0, 2, 0, 0, 0, 'h66);
    vec("R4", 2, 1, 0, 0, 3, 0, 0, 0, 0);
    vec("R4", 1, 1, 0, 'h022, 0, 0, 0, 0, 0);
    // R6 bit set / clear
    vec("R6", 3, 0, 1, 0, 0, 'h12, 0, 0, 'h50);
    vec("R6", 5, 0, 1, 0, 0, 'h12, 0, 2, 0);
    vec("R6", 3, 1, 0, 0, 0, 'h12, 0, 0, 0);
    vec("R6", 6, 0, 1, 0, 0, 'h12, 0, 6, 0);
    vec("R6", 1, 1, 0, 'h032, 0, 0, 0, 0, 0);
    vec("R6", 5, 0, 1, 0, 0, 'h3F, 0, 7, 0);
    vec("R6", 3, 1, 0, 0, 0, 'h3F, 0, 0, 0);
    // R7 low register immediate load
    vec("R7", 4, 0, 1, 0, 0, 0, 5, 0, 'h99);
    vec("R7", 1, 1, 0, 'h005, 0, 0, 0, 0, 0);
    vec("R7", 4, 0, 1, 0, 0, 0, 16, 0, 'h4A);
    vec("R7", 1, 1, 0, 'h010, 0, 0, 0, 0, 0);
    // R8 out of range
    vec("R8", 1, 0, 1, 'h860, 0, 0, 0, 0, 'hEE);
    vec("R8", 1, 1, 0, 'h860, 0, 0, 0, 0, 0);
    vec("R8", 4, 0, 1, 0, 0, 0, 30, 0, 'hFF);
    vec("R8", 4, 0, 1, 0, 0, 0, 31, 0, 'hFF);
    vec("R8", 2, 1, 1, 0, 2, 0, 0, 0, 'h12);
    vec("R8", 1, 1, 0, 'h85F, 0, 0, 0, 0, 0);
    // R10 strobe gating and same-cycle read
    vec("R10", 1, 0, 0, 'h060, 0, 0, 0, 0, 0);
    vec("R10", 0, 1, 0, 'h060, 0, 0, 0, 0, 0);
    vec("R10", 1, 1, 1, 'h070, 0, 0, 0, 0, 'hC3);
    vec("R10", 1, 1, 0, 'h070, 0, 0, 0, 0, 0);
    // R1 mixed random stream
    for (int n = 0; n < 3000; n++) begin
      int o = $urandom_range(0, 7);
      int d = ($urandom_range(0, 3) == 0) ? $urandom_range(24, 33) : $urandom_range(0, 'h8FF);
      vec("R1", o, 1'($urandom), 1'($urandom), d, $urandom_range(0, 3),
          $urandom_range(0, 63), $urandom_range(0, 31), $urandom_range(0, 7),
          $urandom_range(0, 255));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule